// File: doc/BRIEF.md
# Scrambled NRZI Serial Video Encoder

This block turns a stream of 10-bit video or data words into a single serial line bit stream at ten bit clocks per word. Once every ten bit clocks, a word-phase pulse loads one word into a shift register. The register sends the word out least significant bit first. Each serial bit passes through a self-synchronizing scrambler with the polynomial x^9 + x^4 + 1, and then through a transition coder with the polynomial x + 1. A receiver can recover the words without knowing the line polarity and without any side channel to align its scrambler, because its descrambler locks to the incoming bits by itself.

Some sources carry only 8 significant bits. For these, a mode flag sampled with each word widens the word to 10 bits before it is serialized. The all-ones byte becomes the all-ones 10-bit code, and every other byte is moved up by two places with zeros below it. A load pulse whose valid strobe is low sends an all-zero word.

Top module: `scr_nrzi_encoder`

## Requirements
- R1: After reset the scrambler history, the transition coder and the shift register are all zero. `line_out` is 0 during reset and stays 0 until the first word is loaded.
- R2: A word is taken from `word_in`, `word_valid` and `src_narrow` only on a bit clock edge where `word_phase` is 1. Changes on these inputs in other cycles do not affect the transmitted words.
- R3: The bits of a word loaded at edge L reach the line least significant bit first. Bit k is encoded at edge L+1+k, for k = 0..9, so that a pulse every ten clocks gives a gap-free stream.
- R4: The scrambled bit is s = d XOR s(-4) XOR s(-9), where d is the serial data bit and s(-n) is the scrambled bit of n clocks earlier. Descrambling gives back every word.
- R5: Positive logic with transition coding applies. `line_out` toggles on the edge that encodes a scrambled 1 and holds on a scrambled 0. From the zero state, the word 0x001 gives the line bits 1,1,1,1,0,0,0,0,1,0 in transmission order.
- R6: A load with `word_valid` = 0 transmits the word 0x000, whatever `word_in` holds.
- R7: With `src_narrow` = 1, a low byte of 0xFF (word_in[7:0]) is sent as 0x3FF, and word_in[9:8] is ignored.
- R8: With `src_narrow` = 1, any other low byte b is sent as {b, 2'b00}, so 0x00 is sent as 0x000.
- R9: With `src_narrow` = 0, the 10-bit word is sent unchanged.
- R10: Back-to-back words, with a load every ten clocks, each decode correctly. A mode change between words applies only to the word it was loaded with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Serial bit clock, ten cycles per word |
| rst_n | input | 1 | Active-low synchronous reset |
| word_phase | input | 1 | Word-phase enable: load the next word at this edge |
| word_valid | input | 1 | The word on `word_in` is valid; when low, a zero word is loaded |
| src_narrow | input | 1 | 1: the source is 8-bit and the low byte is widened; 0: full 10-bit word |
| word_in | input | 10 | Parallel input word |
| line_out | output | 1 | Scrambled, transition-coded serial line bit |

## Verification
A word loaded at edge L has its bit k encoded into `line_out` by the register at edge L+1+k. The bench samples the line 1 ns after every rising edge and decodes each sample at once, first undoing the transition coding and then multiplying by the scrambler polynomial. It rebuilds word i from the samples taken after edges L+1 through L+10, so the sample taken at a load edge belongs to the previous word. Between loads, the bench drives other values on the word, valid and mode inputs. This shows that only the load edge matters. A fixed line pattern, worked out by hand from the zero state, pins down the bit order and the polarity.

// File: rtl/sdi_enc_pkg.sv
package sdi_enc_pkg;
    localparam int WORD_W   = 10;
    localparam int NARROW_W = 8;
    localparam int SCR_LEN  = 9;
    localparam int SCR_TAP  = 4;

    typedef enum logic {
        SRC_WIDE   = 1'b0,
        SRC_NARROW = 1'b1
    } src_mode_e;
endpackage

// File: rtl/enc_word_widener.sv
module enc_word_widener
    import sdi_enc_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int NB = NARROW_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  src_mode_e    mode,
    input  logic [W-1:0] raw,
    output logic [W-1:0] wide
);
    localparam int PAD = W - NB;

    generate
        if (PAD > 0) begin : g_pad
            logic [W-1:0] wide_d;
            always_comb begin
                wide_d = raw;
                if (mode == SRC_NARROW) begin
                    if (&raw[NB-1:0]) begin
                        wide_d = '1;
                    end else begin
                        wide_d = {raw[NB-1:0], {PAD{1'b0}}};
                    end
                end
            end
            assign wide = wide_d;

            // R7: an all-ones narrow byte becomes the all-ones code
            a_r7_ones_code: assert property (@(posedge clk) disable iff (!rst_n)
                (mode == SRC_NARROW && &raw[NB-1:0]) |-> (&wide));
            // R8: other narrow bytes move up with zero low bits
            a_r8_shift_code: assert property (@(posedge clk) disable iff (!rst_n)
                (mode == SRC_NARROW && !(&raw[NB-1:0])) |->
                (wide[PAD-1:0] == '0 && wide[W-1:PAD] == raw[NB-1:0]));
        end else begin : g_same
            assign wide = raw;
        end
    endgenerate

    // R9: wide mode passes the word through
    a_r9_wide_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SRC_WIDE) |-> (wide == raw));
endmodule

// File: rtl/enc_serializer.sv
module enc_serializer #(
    parameter int W = sdi_enc_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         valid,
    input  logic [W-1:0] word,
    output logic         bit_out
);
    localparam int GW = $clog2(W + 1);
    localparam logic [GW-1:0] GAP_FULL = GW'(W);
    localparam logic [GW-1:0] GAP_LAST = GW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [GW-1:0] gap;
        logic          seen;
    } ser_st_t;

    ser_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sh   = valid ? word : '0;
            st_d.gap  = '0;
            st_d.seen = 1'b1;
        end else begin
            st_d.sh = st_q.sh >> 1;
            if (st_q.gap != GAP_FULL) begin
                st_d.gap = st_q.gap + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sh   <= '0;
            st_q.gap  <= GAP_FULL;
            st_q.seen <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_out = st_q.sh[0];

    // R2: word loads come no closer than one word period apart
    a_r2_load_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (load && st_q.seen) |-> (st_q.gap >= GAP_LAST));
    // R1: a drained or never-loaded register sends zeros
    a_r1_drained_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gap == GAP_FULL) |-> (bit_out == 1'b0));
    // R6: an invalid load leaves an all-zero word
    a_r6_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !valid) |=> (st_q.sh == '0));
endmodule

// File: rtl/enc_scrambler.sv
module enc_scrambler #(
    parameter int LEN = sdi_enc_pkg::SCR_LEN,
    parameter int TAP = sdi_enc_pkg::SCR_TAP
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic bit_out
);
    typedef struct packed {
        logic [LEN-1:0] hist;
    } scr_st_t;

    scr_st_t st_d, st_q;
    logic    scr_bit;

    always_comb begin
        scr_bit = bit_in ^ st_q.hist[TAP-1] ^ st_q.hist[LEN-1];
        st_d.hist = {st_q.hist[LEN-2:0], scr_bit};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hist <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_out = scr_bit;

    // R4: zero data into a cleared history keeps it cleared
    a_r4_zero_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hist == '0 && !bit_in) |=> (st_q.hist == '0));
    // R4: the newest history bit is the bit that was just sent
    a_r4_feedback: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.hist[0] == $past(bit_out)));
endmodule

// File: rtl/enc_nrzi.sv
module enc_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic line
);
    typedef struct packed {
        logic lvl;
    } nrzi_st_t;

    nrzi_st_t st_d, st_q;

    always_comb begin
        st_d.lvl = st_q.lvl ^ bit_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lvl <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line = st_q.lvl;

    // R5: a one toggles the line, a zero holds it
    a_r5_toggle_on_one: assert property (@(posedge clk) disable iff (!rst_n)
        bit_in |=> (line != $past(line)));
    a_r5_hold_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_in |=> $stable(line));
endmodule

// File: rtl/scr_nrzi_encoder.sv
module scr_nrzi_encoder
    import sdi_enc_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int NB  = NARROW_W,
    parameter int LEN = SCR_LEN,
    parameter int TAP = SCR_TAP
) (
    input  logic         clk_bit,
    input  logic         rst_n,
    input  logic         word_phase,
    input  logic         word_valid,
    input  logic         src_narrow,
    input  logic [W-1:0] word_in,
    output logic         line_out
);
    logic [W-1:0] wide_word;
    logic         ser_bit;
    logic         scr_bit;
    src_mode_e    mode;

    assign mode = src_narrow ? SRC_NARROW : SRC_WIDE;

    enc_word_widener #(.W(W), .NB(NB)) u_widen (
        .clk  (clk_bit),
        .rst_n(rst_n),
        .mode (mode),
        .raw  (word_in),
        .wide (wide_word)
    );

    enc_serializer #(.W(W)) u_ser (
        .clk    (clk_bit),
        .rst_n  (rst_n),
        .load   (word_phase),
        .valid  (word_valid),
        .word   (wide_word),
        .bit_out(ser_bit)
    );

    enc_scrambler #(.LEN(LEN), .TAP(TAP)) u_scr (
        .clk    (clk_bit),
        .rst_n  (rst_n),
        .bit_in (ser_bit),
        .bit_out(scr_bit)
    );

    enc_nrzi u_nrzi (
        .clk   (clk_bit),
        .rst_n (rst_n),
        .bit_in(scr_bit),
        .line  (line_out)
    );

    // R1: the line is low in the cycle after reset
    a_r1_reset_low: assert property (@(posedge clk_bit)
        !rst_n |=> (line_out == 1'b0));
endmodule

// File: tb/sim_scr_nrzi_encoder.sv
`timescale 1ns/100ps
module sim_scr_nrzi_encoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       word_phase = 1'b0;
    logic       word_valid = 1'b0;
    logic       src_narrow = 1'b0;
    logic [9:0] word_in = '0;
    logic       line_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic       prev_line = 1'b0;
    logic [8:0] eh = '0;

    logic [9:0] wq [8];
    logic       vq [8];
    logic       nq [8];
    logic       dstream [0:90];
    logic       lstream [0:90];

    always #2.5 clk = ~clk;

    scr_nrzi_encoder u0 (
        .clk_bit   (clk),
        .rst_n     (rst_n),
        .word_phase(word_phase),
        .word_valid(word_valid),
        .src_narrow(src_narrow),
        .word_in   (word_in),
        .line_out  (line_out)
    );

    task automatic check(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bit clock: drive before the edge, sample and decode 1 ns after it
    task automatic tick(input logic ld, input logic v, input logic n8, input logic [9:0] w,
                        output logic ln, output logic db);
        logic e;
        @(negedge clk);
        word_phase = ld;
        word_valid = v;
        src_narrow = n8;
        word_in    = w;
        @(posedge clk);
        #1;
        ln = line_out;
        e = ln ^ prev_line;
        prev_line = ln;
        db = e ^ eh[3] ^ eh[8];
        eh = {eh[7:0], e};
    endtask

    function automatic logic [9:0] expect_word(logic [9:0] w, logic v, logic n8);
        if (!v) return 10'h000;
        if (n8) return (w[7:0] == 8'hFF) ? 10'h3FF : {w[7:0], 2'b00};
        return w;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        word_phase = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(line_out == 1'b0, "R1 line low in reset", {9'd0, line_out}, 10'h000);
        prev_line = 1'b0;
        eh = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // sends n words one per ten clocks, drives other values between loads (R2)
    task automatic run(input int n, input string req);
        logic ln, db;
        logic [9:0] got;
        for (int t = 0; t <= 10 * n; t++) begin
            automatic int i = t / 10;
            if (t % 10 == 0 && i < n) begin
                tick(1'b1, vq[i], nq[i], wq[i], ln, db);
            end else begin
                tick(1'b0, t[0], t[1], 10'(t * 37 + 5), ln, db);
            end
            lstream[t] = ln;
            dstream[t] = db;
        end
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 10; k++) got[k] = dstream[10 * i + 1 + k];
            check(got == expect_word(wq[i], vq[i], nq[i]), req, got,
                  expect_word(wq[i], vq[i], nq[i]));
        end
    endtask

    task automatic idle(input int n);
        logic ln, db;
        for (int t = 0; t < n; t++) tick(1'b0, 1'b1, 1'b0, 10'h3FF, ln, db);
    endtask

    task automatic t_r1_idle();
        logic ln, db;
        logic seen_high;
        seen_high = 1'b0;
        for (int t = 0; t < 20; t++) begin
            tick(1'b0, 1'b1, 1'b0, 10'(t * 51), ln, db);
            if (ln) seen_high = 1'b1;
        end
        check(!seen_high, "R1 idle line low before first load", {9'd0, seen_high}, 10'h000);
    endtask

    task automatic t_r3_r5_pattern(input string req);
        logic [9:0] lines;
        wq[0] = 10'h001; vq[0] = 1'b1; nq[0] = 1'b0;
        run(1, {req, " R4 decode"});
        for (int k = 0; k < 10; k++) lines[k] = lstream[k + 1];
        check(lines == 10'h10F, {req, " line pattern R3 R5"}, lines, 10'h10F);
    endtask

    task automatic t_r9_r10_wide();
        logic [9:0] pat [8] = '{10'h3FF, 10'h000, 10'h2AA, 10'h155, 10'h200, 10'h001, 10'h3FC, 10'h0F0};
        for (int i = 0; i < 8; i++) begin
            wq[i] = pat[i]; vq[i] = 1'b1; nq[i] = 1'b0;
        end
        run(8, "R9 R10 R4 wide back-to-back");
    endtask

    task automatic t_r7_r8_narrow();
        logic [9:0] pat [6] = '{10'h3FF, 10'h0FF, 10'h200, 10'h080, 10'h001, 10'h3FE};
        for (int i = 0; i < 6; i++) begin
            wq[i] = pat[i]; vq[i] = 1'b1; nq[i] = 1'b1;
        end
        run(6, "R7 R8 narrow widening");
    endtask

    task automatic t_r6_invalid();
        wq[0] = 10'h3FF; vq[0] = 1'b0; nq[0] = 1'b0;
        wq[1] = 10'h155; vq[1] = 1'b1; nq[1] = 1'b0;
        wq[2] = 10'h2AA; vq[2] = 1'b0; nq[2] = 1'b1;
        wq[3] = 10'h0C3; vq[3] = 1'b1; nq[3] = 1'b0;
        run(4, "R6 invalid load sends zero");
    endtask

    task automatic t_r2_r10_mixed();
        wq[0] = 10'h0AB; vq[0] = 1'b1; nq[0] = 1'b1;
        wq[1] = 10'h0AB; vq[1] = 1'b1; nq[1] = 1'b0;
        wq[2] = 10'h3FF; vq[2] = 1'b1; nq[2] = 1'b1;
        wq[3] = 10'h3FF; vq[3] = 1'b1; nq[3] = 1'b0;
        wq[4] = 10'h100; vq[4] = 1'b1; nq[4] = 1'b1;
        run(5, "R2 R10 mode per word, other cycles ignored");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_r1_idle();
        t_r3_r5_pattern("R3 R5 first word");
        t_r9_r10_wide();
        idle(13);
        t_r7_r8_narrow();
        t_r6_invalid();
        idle(7);
        t_r2_r10_mixed();
        do_reset();
        t_r3_r5_pattern("R1 R3 R5 after second reset");
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule